// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from a watchdog event, four external pins and eleven internal peripheral event strobes. It keeps a pending flag per maskable source and picks one winner to present to a processor as a 16-bit vector address together with a request line. The processor takes the interrupt by pulsing an acknowledge strobe while the request line is high. The controller then clears the taken source, saves its enable and in-service context, and blocks further maskable acceptance until software re-enables it or pulses the return strobe.

Sixteen maskable sources are ranked in a fixed order, with index 0 the highest. A per-source high-priority flag lifts a source above all low-priority sources. A one-bit in-service flag allows high-priority sources to nest over low-priority service and holds low-priority sources back while high-priority service runs. The watchdog event can be routed to a non-maskable request instead of maskable source 0. A software break strobe has a vector of its own. A standby release level shows any unmasked pending work, whatever the state of the global enable.

Top module: `prio_intc`

## Requirements
- R1: After a synchronous reset, no source is pending, `gie` and `svc_hi` are 0, `irq_req` and `wake` are 0 and `irq_vec` is 0x0000.
- R2: External pin k (k = 0..3) feeds maskable source k+1. With `ext_rise_en[k]` set a 0-to-1 change of the pin is detected, and with `ext_fall_en[k]` set a 1-to-0 change is detected; both may be set. The pending flag is set on the second rising clock edge after the pin changes. A disabled edge sets nothing.
- R3: A high `int_evt[j]` at a clock edge sets pending source j+5. A high `wdt_evt` with `wdt_nmi_sel` = 0 sets pending source 0. Each is visible after that edge.
- R4: `irq_vec` is 0x0004 + 2*s for maskable source s (0x0006 for source 1, 0x0022 for source 15), 0x0004 for the non-maskable request, 0x003E for the software break, and 0x0000 when `irq_req` is low.
- R5: Maskable source s is eligible when it is pending, `src_mask[s]` is 0, `gie` is 1, and either `src_prio_hi[s]` is 1 or `svc_hi` is 0. `irq_req` is high when a source is eligible or a non-maskable or break request is pending.
- R6: Selection order: the non-maskable request first, then the break, then eligible sources with `src_prio_hi` set (lowest index first), then the other eligible sources (lowest index first).
- R7: An `irq_ack` pulse while `irq_req` is high clears the selected pending flag and saves {`gie`, `svc_hi`}. It clears `gie` and sets `svc_hi` to the source's priority flag (1 for the non-maskable request, unchanged for a break). A new event for the same source in that cycle keeps the source pending.
- R8: A `reti` pulse with no acknowledge taken in that cycle restores `gie` and `svc_hi` from the saved copy.
- R9: `wake` is high whenever a pending source is unmasked or the non-maskable request is pending, regardless of `gie` and `svc_hi`.
- R10: With `wdt_nmi_sel` = 1, `wdt_evt` raises the non-maskable request and does not set source 0. This request is accepted whatever the values of `gie`, masks and `svc_hi`.
- R11: `irq_ack` while `irq_req` is low changes no pending flag, `gie` or `svc_hi`.
- R12: `gie_set` sets `gie` and `gie_clr` clears it. When both are high, clear wins. An acknowledge or `reti` in the same cycle takes precedence over both.
- R13: A `brk_req` pulse raises a break request that is accepted with `gie` = 0 and clears on its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 4 | External interrupt pins |
| ext_rise_en | input | 4 | Per-pin rising-edge detect enable |
| ext_fall_en | input | 4 | Per-pin falling-edge detect enable |
| wdt_evt | input | 1 | Watchdog overflow strobe |
| int_evt | input | 11 | Internal peripheral event strobes for sources 5..15 |
| wdt_nmi_sel | input | 1 | 1 routes the watchdog to the non-maskable request |
| src_mask | input | 16 | Per-source mask, 1 = masked |
| src_prio_hi | input | 16 | Per-source priority flag, 1 = high |
| gie_set | input | 1 | Global enable set strobe |
| gie_clr | input | 1 | Global enable clear strobe |
| brk_req | input | 1 | Software break strobe |
| irq_ack | input | 1 | Processor acknowledge strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to processor |
| irq_vec | output | 16 | Vector address of the selected request |
| gie | output | 1 | Global enable state |
| svc_hi | output | 1 | In-service flag, 1 = high-priority service active |
| wake | output | 1 | Standby release level |

## Verification
A stale or wrong pending flag shows on `wake` in the same cycle, and on `irq_vec` as soon as that source is the best eligible one. A corrupted enable or in-service flag shows directly on `gie` and `svc_hi`, and one cycle after an acknowledge or return it changes which of the waiting sources `irq_req` offers. The bench runs a behavioural model alongside the design and compares all five outputs on every clock. Any divergence is therefore reported in the cycle it first reaches a port. Directed sequences cover nesting, held low-priority requests, simultaneous arrivals, watchdog routing and strobes that arrive together.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NUM_SRC   = 16;
    localparam int NUM_EXT   = 4;
    localparam int WDT_SRC   = 0;
    localparam int EXT_BASE  = WDT_SRC + 1;
    localparam int INT_BASE  = EXT_BASE + NUM_EXT;
    localparam int NUM_INT   = NUM_SRC - INT_BASE;
    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam int VEC_W     = 16;
    localparam int VEC_SHIFT = 1;

    localparam logic [VEC_W-1:0] VEC_NMI  = 16'h0004;
    localparam logic [VEC_W-1:0] VEC_BRK  = 16'h003E;
    localparam logic [VEC_W-1:0] VEC_BASE = 16'h0004;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_NMI  = 2'd1,
        K_BRK  = 2'd2,
        K_MASK = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [IDX_W-1:0] idx;
    } grant_t;

    typedef struct packed {
        logic gie;
        logic svc_hi;
    } ctx_t;

    // lowest set index wins
    function automatic logic [IDX_W-1:0] first_set(input logic [NUM_SRC-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input grant_t g);
        logic [VEC_W-1:0] v;
        case (g.kind)
            K_NMI:   v = VEC_NMI;
            K_BRK:   v = VEC_BRK;
            K_MASK:  v = VEC_BASE + (VEC_W'(g.idx) << VEC_SHIFT);
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/intc_edge_det.sv
module intc_edge_det #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] rise_en,
    input  logic [N-1:0] fall_en,
    output logic [N-1:0] evt
);

    logic [N-1:0] cur_q;
    logic [N-1:0] old_q;

    for (genvar k = 0; k < N; k++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) begin
                cur_q[k] <= 1'b0;
                old_q[k] <= 1'b0;
            end else begin
                cur_q[k] <= pin[k];
                old_q[k] <= cur_q[k];
            end
        end

        assign evt[k] = (rise_en[k] &  cur_q[k] & ~old_q[k]) |
                        (fall_en[k] & ~cur_q[k] &  old_q[k]);
    end

endmodule

// File: rtl/intc_req_bank.sv
module intc_req_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] pend
);

    for (genvar s = 0; s < N; s++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                pend[s] <= 1'b0;
            else if (set_vec[s])
                pend[s] <= 1'b1;
            else if (clr_vec[s])
                pend[s] <= 1'b0;
        end

        // R3 / R7: a new event always lands, even against a clear
        a_r3_set_lands: assert property (@(posedge clk) disable iff (rst)
            set_vec[s] |=> pend[s]);
    end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    input  logic [NUM_SRC-1:0] prio_hi,
    input  logic               gie,
    input  logic               svc_hi,
    input  logic               nmi_pend,
    input  logic               brk_pend,
    output grant_t             grant,
    output logic               req,
    output logic [VEC_W-1:0]   vec
);

    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] elig_hi;

    always_comb begin
        elig    = pend & ~mask & {NUM_SRC{gie}} & (prio_hi | {NUM_SRC{~svc_hi}});
        elig_hi = elig & prio_hi;
    end

    always_comb begin
        grant.kind = K_NONE;
        grant.idx  = '0;
        if (nmi_pend) begin
            grant.kind = K_NMI;
        end else if (brk_pend) begin
            grant.kind = K_BRK;
        end else if (|elig_hi) begin
            grant.kind = K_MASK;
            grant.idx  = first_set(elig_hi);
        end else if (|elig) begin
            grant.kind = K_MASK;
            grant.idx  = first_set(elig);
        end
    end

    assign req = (grant.kind != K_NONE);
    assign vec = vec_of(grant);

    // R5: a low-priority source is never offered during high-priority service
    a_r5_low_held: assert property (@(posedge clk) disable iff (rst)
        (grant.kind == K_MASK && svc_hi) |-> prio_hi[grant.idx]);

    // R6: a granted maskable source must actually be pending and unmasked
    a_r6_grant_valid: assert property (@(posedge clk) disable iff (rst)
        (grant.kind == K_MASK) |-> (pend[grant.idx] && !mask[grant.idx]));

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_EXT-1:0]   ext_pin,
    input  logic [NUM_EXT-1:0]   ext_rise_en,
    input  logic [NUM_EXT-1:0]   ext_fall_en,
    input  logic                 wdt_evt,
    input  logic [NUM_INT-1:0]   int_evt,
    input  logic                 wdt_nmi_sel,
    input  logic [NUM_SRC-1:0]   src_mask,
    input  logic [NUM_SRC-1:0]   src_prio_hi,
    input  logic                 gie_set,
    input  logic                 gie_clr,
    input  logic                 brk_req,
    input  logic                 irq_ack,
    input  logic                 reti,
    output logic                 irq_req,
    output logic [VEC_W-1:0]     irq_vec,
    output logic                 gie,
    output logic                 svc_hi,
    output logic                 wake
);

    logic [NUM_EXT-1:0] ext_evt;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] pend;
    logic               nmi_pend;
    logic               brk_pend;
    logic               take;
    grant_t             grant;
    ctx_t               saved;

    intc_edge_det #(.N(NUM_EXT)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .pin     (ext_pin),
        .rise_en (ext_rise_en),
        .fall_en (ext_fall_en),
        .evt     (ext_evt)
    );

    always_comb begin
        set_vec                       = '0;
        set_vec[WDT_SRC]              = wdt_evt & ~wdt_nmi_sel;
        set_vec[EXT_BASE +: NUM_EXT]  = ext_evt;
        set_vec[INT_BASE +: NUM_INT]  = int_evt;
    end

    assign take = irq_req & irq_ack;

    always_comb begin
        clr_vec = '0;
        if (take && grant.kind == K_MASK)
            clr_vec[grant.idx] = 1'b1;
    end

    intc_req_bank #(.N(NUM_SRC)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend    (pend)
    );

    intc_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .pend     (pend),
        .mask     (src_mask),
        .prio_hi  (src_prio_hi),
        .gie      (gie),
        .svc_hi   (svc_hi),
        .nmi_pend (nmi_pend),
        .brk_pend (brk_pend),
        .grant    (grant),
        .req      (irq_req),
        .vec      (irq_vec)
    );

    // non-maskable and break request latches
    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_pend <= 1'b0;
            brk_pend <= 1'b0;
        end else begin
            if (wdt_evt && wdt_nmi_sel)
                nmi_pend <= 1'b1;
            else if (take && grant.kind == K_NMI)
                nmi_pend <= 1'b0;

            if (brk_req)
                brk_pend <= 1'b1;
            else if (take && grant.kind == K_BRK)
                brk_pend <= 1'b0;
        end
    end

    // enable / in-service context with a one-entry save slot
    always_ff @(posedge clk) begin
        if (rst) begin
            gie    <= 1'b0;
            svc_hi <= 1'b0;
            saved  <= '0;
        end else if (take) begin
            saved.gie    <= gie;
            saved.svc_hi <= svc_hi;
            gie          <= 1'b0;
            case (grant.kind)
                K_NMI:   svc_hi <= 1'b1;
                K_MASK:  svc_hi <= src_prio_hi[grant.idx];
                default: svc_hi <= svc_hi;
            endcase
        end else if (reti) begin
            gie    <= saved.gie;
            svc_hi <= saved.svc_hi;
        end else if (gie_clr) begin
            gie <= 1'b0;
        end else if (gie_set) begin
            gie <= 1'b1;
        end
    end

    assign wake = (|(pend & ~src_mask)) | nmi_pend;

    // R7: taking an interrupt drops the global enable
    a_r7_ack_clears_gie: assert property (@(posedge clk) disable iff (rst)
        take |=> !gie);

    // R8: return restores the saved context
    a_r8_reti_restores: assert property (@(posedge clk) disable iff (rst)
        (reti && !take) |=> (gie == $past(saved.gie) && svc_hi == $past(saved.svc_hi)));

    // R11: an acknowledge with nothing offered leaves the context alone
    a_r11_idle_ack: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !irq_req && !reti && !gie_set && !gie_clr)
        |=> (gie == $past(gie) && svc_hi == $past(svc_hi)));

    // R5: a maskable request is only offered with the global enable set
    a_r5_req_needs_gie: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !nmi_pend && !brk_pend) |-> gie);

    // R10: the non-maskable request always wins and is always offered
    a_r10_nmi_vector: assert property (@(posedge clk) disable iff (rst)
        nmi_pend |-> (irq_req && irq_vec == VEC_NMI));

    // R12: clear wins over set
    a_r12_clr_wins: assert property (@(posedge clk) disable iff (rst)
        (gie_set && gie_clr && !take && !reti) |=> !gie);

endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  ext_pin, ext_rise_en, ext_fall_en;
    logic        wdt_evt, wdt_nmi_sel;
    logic [10:0] int_evt;
    logic [15:0] src_mask, src_prio_hi;
    logic        gie_set, gie_clr, brk_req, irq_ack, reti;
    logic        irq_req, gie, svc_hi, wake;
    logic [15:0] irq_vec;

    int    n_chk  = 0;
    int    n_fail = 0;
    string phase  = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    prio_intc u_dut (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .ext_rise_en(ext_rise_en),
        .ext_fall_en(ext_fall_en), .wdt_evt(wdt_evt), .int_evt(int_evt),
        .wdt_nmi_sel(wdt_nmi_sel), .src_mask(src_mask), .src_prio_hi(src_prio_hi),
        .gie_set(gie_set), .gie_clr(gie_clr), .brk_req(brk_req), .irq_ack(irq_ack),
        .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec), .gie(gie),
        .svc_hi(svc_hi), .wake(wake)
    );

    // ---------------- behavioural reference model ----------------
    bit [15:0] m_pend;
    bit        m_nmi, m_brk, m_gie, m_svc, m_sv_gie, m_sv_svc;
    bit [3:0]  m_now, m_before;

    function automatic bit elig(int s);
        return m_pend[s] && !src_mask[s] && m_gie && (src_prio_hi[s] || !m_svc);
    endfunction

    // kind: 0 none, 1 nmi, 2 brk, 3 maskable
    function automatic void m_pick(output int kind, output int idx, output int vec);
        kind = 0; idx = -1; vec = 0;
        if (m_nmi) begin kind = 1; vec = 'h4; end
        else if (m_brk) begin kind = 2; vec = 'h3E; end
        else begin
            for (int s = 0; s < 16; s++)
                if (idx < 0 && elig(s) && src_prio_hi[s]) idx = s;
            for (int s = 0; s < 16; s++)
                if (idx < 0 && elig(s)) idx = s;
            if (idx >= 0) begin kind = 3; vec = 4 + 2 * idx; end
        end
    endfunction

    always @(posedge clk) begin
        int k, i, v;
        bit tk;
        if (rst) begin
            m_pend = '0; m_nmi = 0; m_brk = 0; m_gie = 0; m_svc = 0;
            m_sv_gie = 0; m_sv_svc = 0; m_now = '0; m_before = '0;
        end else begin
            m_pick(k, i, v);
            tk = (k != 0) && irq_ack;
            if (tk && k == 3) m_pend[i] = 0;
            if (wdt_evt && !wdt_nmi_sel) m_pend[0] = 1;
            for (int p = 0; p < 4; p++)
                if ((ext_rise_en[p] && m_now[p] && !m_before[p]) ||
                    (ext_fall_en[p] && !m_now[p] && m_before[p]))
                    m_pend[1 + p] = 1;
            for (int j = 0; j < 11; j++)
                if (int_evt[j]) m_pend[5 + j] = 1;
            if (wdt_evt && wdt_nmi_sel) m_nmi = 1;
            else if (tk && k == 1) m_nmi = 0;
            if (brk_req) m_brk = 1;
            else if (tk && k == 2) m_brk = 0;
            if (tk) begin
                m_sv_gie = m_gie; m_sv_svc = m_svc; m_gie = 0;
                if (k == 1) m_svc = 1;
                else if (k == 3) m_svc = src_prio_hi[i];
            end else if (reti) begin
                m_gie = m_sv_gie; m_svc = m_sv_svc;
            end else if (gie_clr) m_gie = 0;
            else if (gie_set) m_gie = 1;
            m_before = m_now;
            m_now    = ext_pin;
        end
    end

    // ---------------- checking ----------------
    task automatic cmp(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", phase, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int k, i, v;
        m_pick(k, i, v);
        cmp("irq_req", int'(irq_req), int'(k != 0));
        cmp("irq_vec", int'(irq_vec), v);
        cmp("gie", int'(gie), int'(m_gie));
        cmp("svc_hi", int'(svc_hi), int'(m_svc));
        cmp("wake", int'(wake), int'((|(m_pend & ~src_mask)) || m_nmi));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic ticks(int n);
        for (int c = 0; c < n; c++) tick();
    endtask

    task automatic pulse_int(int j);
        int_evt[j] = 1'b1; tick(); int_evt[j] = 1'b0;
    endtask

    task automatic do_ack();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1; tick(); reti = 1'b0;
    endtask

    task automatic do_gie_set();
        gie_set = 1'b1; tick(); gie_set = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        ext_pin = '0; ext_rise_en = '0; ext_fall_en = '0;
        wdt_evt = 0; wdt_nmi_sel = 0; int_evt = '0;
        src_mask = '0; src_prio_hi = '0;
        gie_set = 0; gie_clr = 0; brk_req = 0; irq_ack = 0; reti = 0;

        // R1 reset state
        phase = "R1";
        ticks(3);
        cmp("reset irq_vec", int'(irq_vec), 0);
        rst = 1'b0;
        tick();

        // R3 / R9: internal event pends with gie low, wake rises, no request
        phase = "R3";
        pulse_int(3);
        phase = "R9";
        cmp("wake with gie=0", int'(wake), 1);
        cmp("irq_req with gie=0", int'(irq_req), 0);
        // R12 enable, then R4 vector of source 8
        phase = "R12";
        do_gie_set();
        phase = "R4";
        cmp("vector src8", int'(irq_vec), 'h14);
        // R7 acknowledge, R8 return
        phase = "R7";
        do_ack();
        cmp("gie after ack", int'(gie), 0);
        phase = "R8";
        do_reti();
        cmp("gie after reti", int'(gie), 1);

        // R2 external edges
        phase = "R2";
        ext_rise_en = 4'b1001; ext_fall_en = 4'b1100;
        ext_pin[0] = 1'b1; tick();
        cmp("pin0 not yet pending", int'(irq_req), 0);
        tick();
        cmp("pin0 rise vector", int'(irq_vec), 'h6);
        do_ack(); do_reti();
        ext_pin[1] = 1'b1; ticks(3);
        cmp("pin1 no edge enabled", int'(wake), 0);
        ext_pin[2] = 1'b1; ticks(3);
        cmp("pin2 rise ignored", int'(irq_req), 0);
        ext_pin[2] = 1'b0; ticks(2);
        cmp("pin2 fall vector", int'(irq_vec), 'hA);
        do_ack(); do_reti();
        ext_pin[3] = 1'b1; ticks(2);
        cmp("pin3 rise vector", int'(irq_vec), 'hC);
        do_ack(); do_reti();
        ext_pin[3] = 1'b0; ticks(2);
        cmp("pin3 fall vector", int'(irq_vec), 'hC);
        do_ack(); do_reti();

        // R9 masked source gives neither wake nor request
        phase = "R9";
        src_mask[15] = 1'b1;
        pulse_int(10);
        cmp("masked wake", int'(wake), 0);
        src_mask[15] = 1'b0; tick();
        phase = "R4";
        cmp("vector src15", int'(irq_vec), 'h22);
        do_ack(); do_reti();

        // R6 simultaneous arrivals with one high-priority source
        phase = "R6";
        src_prio_hi[13] = 1'b1;
        int_evt[1] = 1'b1; int_evt[8] = 1'b1; int_evt[0] = 1'b1;
        tick(); int_evt = '0;
        cmp("high flag first", int'(irq_vec), 'h1E);
        do_ack(); do_reti();
        cmp("then lowest index", int'(irq_vec), 'hE);
        do_ack(); do_reti();
        cmp("then next", int'(irq_vec), 'h10);
        do_ack(); do_reti();

        // R5 nesting: low service, high nests, low held
        phase = "R5";
        src_prio_hi = '0; src_prio_hi[10] = 1'b1;
        pulse_int(3);
        do_ack();
        do_gie_set();
        pulse_int(5);
        cmp("high nests over low", int'(irq_vec), 'h18);
        do_ack();
        cmp("svc_hi set", int'(svc_hi), 1);
        do_gie_set();
        pulse_int(7);
        cmp("low held in high service", int'(irq_req), 0);
        do_reti();
        cmp("low offered after return", int'(irq_vec), 'h1C);
        do_ack(); do_reti();

        // R11 acknowledge with nothing offered
        phase = "R11";
        irq_ack = 1'b1; ticks(2); irq_ack = 1'b0;
        cmp("gie kept", int'(gie), 1);

        // R3 watchdog as maskable source 0
        phase = "R3";
        wdt_evt = 1'b1; tick(); wdt_evt = 1'b0;
        cmp("wdt maskable vector", int'(irq_vec), 'h4);
        do_ack(); do_reti();

        // R10 watchdog as non-maskable, gie low and all masked
        phase = "R10";
        wdt_nmi_sel = 1'b1; src_mask = '1;
        gie_clr = 1'b1; tick(); gie_clr = 1'b0;
        wdt_evt = 1'b1; tick(); wdt_evt = 1'b0;
        cmp("nmi offered", int'(irq_req), 1);
        cmp("nmi wake", int'(wake), 1);
        do_ack();
        cmp("nmi svc_hi", int'(svc_hi), 1);
        do_reti();
        src_mask = '0; wdt_nmi_sel = 1'b0;

        // R13 break accepted with gie low
        phase = "R13";
        brk_req = 1'b1; tick(); brk_req = 1'b0;
        cmp("break vector", int'(irq_vec), 'h3E);
        do_ack();
        cmp("break cleared", int'(irq_req), 0);
        do_reti();

        // R12 set and clear together
        phase = "R12";
        do_gie_set();
        gie_set = 1'b1; gie_clr = 1'b1; tick(); gie_set = 1'b0; gie_clr = 1'b0;
        cmp("clear wins", int'(gie), 0);

        // R7 event for the source being acknowledged keeps it pending
        phase = "R7";
        do_gie_set();
        pulse_int(2);
        int_evt[2] = 1'b1; irq_ack = 1'b1; tick();
        int_evt[2] = 1'b0; irq_ack = 1'b0;
        cmp("re-event survives ack", int'(wake), 1);
        do_reti();

        // R4 every maskable vector in turn
        phase = "R4";
        for (int j = 0; j < 11; j++) begin
            pulse_int(j);
            cmp("vector sweep", int'(irq_vec), 4 + 2 * (5 + j));
            do_ack(); do_reti();
        end

        ticks(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule